// File: doc/BRIEF.md
# Per-Cell Offset Correction Unit

This unit removes the fixed-pattern offset from a stream of 12-bit samples read out of a switched-capacitor waveform recorder. Each storage cell of a 1024-cell channel has its own offset word. The unit keeps these words in a table and subtracts the right one from every sample. The corrected value is clamped to the 12-bit range, and it leaves the unit two cycles after the sample enters.

Readout of an event starts at the cell where sampling stopped, not at cell 0. A start-of-event strobe loads that stop cell into a running cell pointer. Every accepted sample then moves the pointer on by one, and the pointer wraps from the last cell back to cell 0. The table is filled through a plain write port while no event is streaming. Offsets are stored as 13-bit two's-complement values.

Top module: `cell_offset_corr`

## Requirements
- R1: While reset is asserted, and at the first cycle after it, out_valid_o is 0 and out_data_o is 0.
- R2: out_valid_o equals smp_valid_i delayed by exactly two clock cycles.
- R3: If sample minus offset is below zero, out_data_o is 0.
- R4: If sample minus offset is above 4095, out_data_o is 4095.
- R5: If sample minus offset lies in 0..4095, out_data_o equals that difference exactly. The offset is read as 13-bit two's complement.
- R6: A cycle with sof_i high loads stop_cell_i into the cell pointer. After that, the k-th valid sample uses the offset of cell (stop + k) mod 1024, counting from k = 0. Cycles with smp_valid_i low do not advance the pointer.
- R7: The pointer wraps from cell 1023 to cell 0.
- R8: If sof_i and smp_valid_i are high in the same cycle, that sample still uses the old event's pointer. The next valid sample uses the new stop cell.
- R9: A write with tbl_we_i high stores tbl_data_i at cell tbl_addr_i. Later events use the new value. Writes are made only in cycles with smp_valid_i low.
- R10: In a cycle where out_valid_o is 0, out_data_o keeps the value it had in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sof_i | input | 1 | Start-of-event strobe; loads the stop cell |
| stop_cell_i | input | 10 | Cell where sampling stopped for the new event |
| smp_valid_i | input | 1 | Input sample valid |
| smp_data_i | input | 12 | Raw input sample |
| tbl_we_i | input | 1 | Offset table write enable |
| tbl_addr_i | input | 10 | Offset table write address (cell number) |
| tbl_data_i | input | 13 | Offset value, two's complement |
| out_valid_o | output | 1 | Corrected sample valid |
| out_data_o | output | 12 | Corrected, saturated sample |

## Verification
The start-of-event strobe for the next event can arrive in the same cycle as the last sample of the current event. That sample must still take its offset from the old pointer, and the first sample of the new event must take the new stop cell. The bench sets this up on purpose in directed events and at random in chained events. It then compares every corrected word against a model that first uses the pointer and only afterwards reloads it. A second overlap case is a sample arriving as the pointer wraps from 1023 to 0. Stop cells near the top of the table make this happen, and the model's expected values judge each such sample.

// File: rtl/ofs_corr_pkg.sv
package ofs_corr_pkg;
  localparam int unsigned DEF_CELLS = 1024;
  localparam int unsigned DEF_SMP_W = 12;
  localparam int unsigned DEF_OFS_W = 13;
endpackage

// File: rtl/ofs_cell_ptr.sv
module ofs_cell_ptr #(
  parameter int unsigned CELLS = 1024,
  parameter int unsigned AW    = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sof_i,
  input  logic [AW-1:0] stop_cell_i,
  input  logic          adv_i,
  output logic [AW-1:0] cell_o
);
  localparam bit POW2 = (CELLS == (1 << AW));

  logic [AW-1:0] cell_q;
  logic [AW-1:0] cell_nxt;

  generate
    if (POW2) begin : g_pow2
      assign cell_nxt = cell_q + 1'b1;
    end else begin : g_mod
      assign cell_nxt = (cell_q == AW'(CELLS - 1)) ? '0 : cell_q + 1'b1;
    end
  endgenerate

  // strobe wins: a sample in the same cycle already used the old pointer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cell_q <= '0;
    else if (sof_i) cell_q <= stop_cell_i;
    else if (adv_i) cell_q <= cell_nxt;
  end

  assign cell_o = cell_q;
endmodule

// File: rtl/ofs_table.sv
module ofs_table #(
  parameter int unsigned CELLS = 1024,
  parameter int unsigned AW    = 10,
  parameter int unsigned OW    = 13
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [OW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [OW-1:0] rdata_o
);
  logic [OW-1:0] mem [CELLS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/ofs_sub_sat.sv
module ofs_sub_sat #(
  parameter int unsigned SW = 12,
  parameter int unsigned OW = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [SW-1:0] smp_i,
  input  logic [OW-1:0] ofs_i,
  output logic          valid_o,
  output logic [SW-1:0] data_o
);
  localparam int unsigned DW = ((SW + 1 > OW) ? SW + 1 : OW) + 1;

  logic signed [DW-1:0] smp_ext;
  logic signed [DW-1:0] ofs_ext;
  logic signed [DW-1:0] diff;
  logic [SW-1:0]        sat;

  assign smp_ext = $signed({{(DW - SW){1'b0}}, smp_i});
  assign ofs_ext = DW'($signed(ofs_i));
  assign diff    = smp_ext - ofs_ext;

  always_comb begin
    if (diff[DW-1])          sat = '0;
    else if (|diff[DW-2:SW]) sat = '1;
    else                     sat = diff[SW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= sat;
    end
  end
endmodule

// File: rtl/cell_offset_corr.sv
module cell_offset_corr
  import ofs_corr_pkg::*;
#(
  parameter int unsigned CELLS = DEF_CELLS,
  parameter int unsigned SMP_W = DEF_SMP_W,
  parameter int unsigned OFS_W = DEF_OFS_W,
  localparam int unsigned AW   = $clog2(CELLS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sof_i,
  input  logic [AW-1:0]    stop_cell_i,
  input  logic             smp_valid_i,
  input  logic [SMP_W-1:0] smp_data_i,
  input  logic             tbl_we_i,
  input  logic [AW-1:0]    tbl_addr_i,
  input  logic [OFS_W-1:0] tbl_data_i,
  output logic             out_valid_o,
  output logic [SMP_W-1:0] out_data_o
);
  logic [AW-1:0]    cell_w;
  logic [OFS_W-1:0] ofs_w;
  logic             v1_q;
  logic [SMP_W-1:0] s1_q;

  ofs_cell_ptr #(.CELLS(CELLS), .AW(AW)) u_ptr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sof_i       (sof_i),
    .stop_cell_i (stop_cell_i),
    .adv_i       (smp_valid_i),
    .cell_o      (cell_w)
  );

  ofs_table #(.CELLS(CELLS), .AW(AW), .OW(OFS_W)) u_tbl (
    .clk_i   (clk_i),
    .we_i    (tbl_we_i),
    .waddr_i (tbl_addr_i),
    .wdata_i (tbl_data_i),
    .re_i    (smp_valid_i),
    .raddr_i (cell_w),
    .rdata_o (ofs_w)
  );

  // stage 1: sample aligned with the table read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q <= 1'b0;
      s1_q <= '0;
    end else begin
      v1_q <= smp_valid_i;
      if (smp_valid_i) s1_q <= smp_data_i;
    end
  end

  ofs_sub_sat #(.SW(SMP_W), .OW(OFS_W)) u_sub (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (v1_q),
    .smp_i   (s1_q),
    .ofs_i   (ofs_w),
    .valid_o (out_valid_o),
    .data_o  (out_data_o)
  );
endmodule

// File: rtl/cell_offset_corr_chk.sv
module cell_offset_corr_chk #(
  parameter int unsigned CELLS = 1024,
  parameter int unsigned AW    = 10,
  parameter int unsigned SMP_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sof_i,
  input logic [AW-1:0]    stop_cell_i,
  input logic             smp_valid_i,
  input logic             tbl_we_i,
  input logic [AW-1:0]    cell_q,
  input logic             out_valid_o,
  input logic [SMP_W-1:0] out_data_o
);
  logic [1:0] cyc;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  p_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc == 2'd3) |-> (out_valid_o == $past(smp_valid_i, 2)));

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc != 2'd0 && !out_valid_o) |-> $stable(out_data_o));

  p_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |=> (cell_q == $past(stop_cell_i)));

  p_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!smp_valid_i && !sof_i) |=> $stable(cell_q));

  p_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && !sof_i) |=>
      (cell_q == (($past(cell_q) == AW'(CELLS - 1)) ? AW'(0) : AW'($past(cell_q) + 1'b1))));

  p_quiet_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_we_i |-> !smp_valid_i);
endmodule

bind cell_offset_corr cell_offset_corr_chk #(.CELLS(CELLS), .AW(AW), .SMP_W(SMP_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sof_i       (sof_i),
  .stop_cell_i (stop_cell_i),
  .smp_valid_i (smp_valid_i),
  .tbl_we_i    (tbl_we_i),
  .cell_q      (cell_w),
  .out_valid_o (out_valid_o),
  .out_data_o  (out_data_o)
);

// File: tb/cell_offset_corr_bench.sv
module cell_offset_corr_bench;
  localparam int CELLS = 1024;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sof_i = 1'b0;
  logic [9:0]  stop_cell_i = '0;
  logic        smp_valid_i = 1'b0;
  logic [11:0] smp_data_i = '0;
  logic        tbl_we_i = 1'b0;
  logic [9:0]  tbl_addr_i = '0;
  logic [12:0] tbl_data_i = '0;
  logic        out_valid_o;
  logic [11:0] out_data_o;

  always #10 clk_i = ~clk_i;

  cell_offset_corr u_cell_offset_corr (.*);

  int n_chk = 0;
  int n_fail = 0;
  int ofs_m [CELLS];
  int idx_m = 0;
  int last_out = 0;
  bit    dl1_v = 0, dl2_v = 0;
  int    dl1_d = 0, dl2_d = 0;
  string dl1_t = "", dl2_t = "";
  string ctx = "";

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_out(input int d, input int o, output string tag);
    int df = d - o;
    if (df < 0)         begin tag = "R3"; return 0;    end
    else if (df > 4095) begin tag = "R4"; return 4095; end
    tag = "R5";
    return df;
  endfunction

  // one cycle, entered and left at a falling edge
  task automatic cyc(input bit v, input int d, input bit s, input int st,
                     input bit we, input int wa, input int wd);
    string tg;
    int e;
    if (dl2_v) begin
      chk(out_valid_o == 1'b1, {"R2 ", dl2_t}, out_valid_o, 1);
      chk(out_data_o == dl2_d[11:0], dl2_t, out_data_o, dl2_d);
      last_out = dl2_d;
    end else begin
      chk(out_valid_o == 1'b0, "R2 idle", out_valid_o, 0);
      chk(out_data_o == last_out[11:0], "R10 hold", out_data_o, last_out);
    end
    smp_valid_i = v; smp_data_i = d[11:0];
    sof_i = s; stop_cell_i = st[9:0];
    tbl_we_i = we; tbl_addr_i = wa[9:0]; tbl_data_i = wd[12:0];
    dl2_v = dl1_v; dl2_d = dl1_d; dl2_t = dl1_t;
    dl1_v = v;
    if (v) begin
      e = model_out(d, ofs_m[idx_m], tg);
      dl1_d = e; dl1_t = {tg, " ", ctx};
      idx_m = (idx_m + 1) % CELLS;
    end
    if (s) idx_m = st;
    if (we) ofs_m[wa] = int'($signed(wd[12:0]));
    @(negedge clk_i);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic wr(input int a, input int o);
    cyc(0, 0, 0, 0, 1, a, o & 32'h1fff);
  endtask

  task automatic rnd_data(output int d);
    int r = $urandom_range(0, 15);
    if (r == 0)      d = 0;
    else if (r == 1) d = 4095;
    else             d = $urandom_range(0, 4095);
  endtask

  // chain: last sample carries the next event's strobe (R8)
  task automatic run_event(input int st, input int len, input bit pre_sof,
                           input bit chain, input int nst, input bit gaps);
    int d;
    if (pre_sof) cyc(0, 0, 1, st, 0, 0, 0);
    for (int k = 0; k < len; k++) begin
      if (gaps && $urandom_range(0, 3) == 0) idle(1);
      rnd_data(d);
      if (k == len - 1 && chain) cyc(1, d, 1, nst, 0, 0, 0);
      else cyc(1, d, 0, 0, 0, 0, 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1a2b3c4d));
    repeat (3) @(negedge clk_i);
    chk(out_valid_o == 1'b0, "R1 valid in reset", out_valid_o, 0);
    chk(out_data_o == 12'd0, "R1 data in reset", out_data_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(out_valid_o == 1'b0, "R1 valid after reset", out_valid_o, 0);
    chk(out_data_o == 12'd0, "R1 data after reset", out_data_o, 0);

    ctx = "R9 load";
    for (int a = 0; a < CELLS; a++) begin
      int o = $urandom_range(0, 255) - 128;
      if ($urandom_range(0, 31) == 0) o = $urandom_range(0, 8191) - 4096;
      wr(a, o);
    end
    wr(5, -4096);
    wr(7, 4095);
    wr(6, 0);

    ctx = "R6 R7 wrap event";
    run_event(1018, 12, 1, 0, 0, 1);
    idle(3);

    ctx = "R3 R4 R5 directed";
    cyc(0, 0, 1, 5, 0, 0, 0);
    cyc(1, 4000, 0, 0, 0, 0, 0);
    cyc(1, 1234, 0, 0, 0, 0, 0);
    cyc(1, 100, 0, 0, 0, 0, 0);
    cyc(1, 4095, 0, 0, 0, 0, 0);
    idle(3);

    ctx = "R8 strobe with last sample";
    run_event(1020, 6, 1, 1, 3, 0);
    run_event(0, 5, 0, 1, 1022, 1);
    run_event(0, 4, 0, 0, 0, 0);
    idle(3);

    ctx = "R9 rewrite";
    for (int a = 200; a < 210; a++) wr(a, $urandom_range(0, 4000) - 2000);
    run_event(198, 14, 1, 0, 0, 0);
    idle(2);

    ctx = "R6 random events";
    for (int ev = 0; ev < 24; ev++) begin
      bit ch = ($urandom_range(0, 2) == 0);
      run_event($urandom_range(0, CELLS - 1), $urandom_range(1, 1400), 1, ch,
                $urandom_range(0, CELLS - 1), 1);
      if (ch) run_event(0, $urandom_range(1, 40), 0, 0, 0, 1);
      idle($urandom_range(0, 3));
      if ($urandom_range(0, 3) == 0) begin
        ctx = "R9 random rewrite";
        wr($urandom_range(0, CELLS - 1), $urandom_range(0, 8191) - 4096);
        ctx = "R6 random events";
      end
    end
    idle(4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule